// File: doc/BRIEF.md
# Lifting-Step Context Store

This block is the small configuration memory that sits beside one lifting processing element. It keeps several complete lifting-step setups and feeds one of them to the datapath. A setup holds two multiplier constants, two tap selects, a flag for a future-sample tap, a bypass flag, a right-shift amount and a normalize flag. All elements in a chain hear one shared load bus. Each load carries a row number, a context number, the two constants on the data lines and the packed select fields on a separate control word. An element stores a load only when the row number equals its own fixed row index, which is set by a parameter.

The controller drives a context number and pulses a step-boundary strobe when a new lifting step begins. On that strobe the store copies the addressed setup into its output register, and the datapath sees it one clock later. Between strobes the outputs stay frozen. A step that is already running therefore keeps its setup, even if the select input moves or the active entry is written again. Elements at the ends of the chain can normalize. Middle elements are built with normalization removed, and their normalize flag always reads zero.

Top module: `lctx_store`

## Requirements
- R1: After reset, every output shows the bypass setup: both constants 0, bypass 1, and every other field 0. Context 0 holds this same setup and every other context holds all zeros.
- R2: A load with `cfg_wr` high changes context `cfg_ctx` only when `cfg_row` equals the parameter `ROW_ID`. A load for any other row leaves every context unchanged.
- R3: The control word layout is: bits [2:0] tap p, [5:3] tap q, [9:6] shift, [10] future select, [11] bypass, [12] normalize. These positions hold for the default widths. A stored setup is returned field for field.
- R4: When `step_start` is high at a clock edge, the outputs take the setup stored at `ctx_sel` and show it from the next cycle on.
- R5: While `step_start` is low, the outputs do not change. This holds when `ctx_sel` moves, and it holds when the active context is rewritten.
- R6: If a load and a step start happen at the same edge on the same context, the outputs show the value stored before the load. The new value appears at the next step start.
- R7: When `NORM_EN` is 0, the normalize output is always 0 and every other field loads normally.
- R8: Every context from 0 to `NUM_CTX`-1 can be loaded and selected, including the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe on the shared bus |
| cfg_row | input | ROW_W | Row number the load is aimed at |
| cfg_ctx | input | CTX_W | Context number being loaded |
| cfg_coef_a | input | COEF_W | First constant, carried on the data lines |
| cfg_coef_b | input | COEF_W | Second constant, carried on the data lines |
| cfg_ctrl | input | CTRL_W | Packed select fields, carried on the control lines |
| step_start | input | 1 | Step-boundary strobe; latches the selected setup |
| ctx_sel | input | CTX_W | Context chosen for the next step |
| act_coef_a | output | COEF_W | Active first constant |
| act_coef_b | output | COEF_W | Active second constant |
| act_tap_p | output | TAP_W | Active first tap select |
| act_tap_q | output | TAP_W | Active second tap select |
| act_shift | output | SHIFT_W | Active right-shift amount |
| act_future | output | 1 | Active future-sample select |
| act_bypass | output | 1 | Active bypass flag |
| act_norm | output | 1 | Active normalize flag |

## Verification
The hardest case to reach is a load and a step start landing on the same context in the same cycle. The bench creates it by raising `cfg_wr` and `step_start` together, with `cfg_ctx` equal to `ctx_sel`. It expects the old contents at once and the new contents after a second strobe. It also rewrites the active context in the middle of a step and moves `ctx_sel` with no strobe. It then watches the outputs for several cycles to show that the running step keeps its setup. A second instance, built as a middle element, hears the same bus and shows that a normalize bit which was loaded is dropped.

// File: rtl/lctx_pkg.sv
package lctx_pkg;
   // width of the packed control word: two taps, shift, future, bypass, normalize
   function automatic int ctrl_width(input int tap_w, input int shift_w);
      return 2 * tap_w + shift_w + 3;
   endfunction

   function automatic int norm_pos(input int ctrl_w);
      return ctrl_w - 1;
   endfunction

   function automatic int bypass_pos(input int ctrl_w);
      return ctrl_w - 2;
   endfunction

   function automatic int future_pos(input int ctrl_w);
      return ctrl_w - 3;
   endfunction
endpackage

// File: rtl/lctx_wr_gate.sv
module lctx_wr_gate #(
   parameter int NUM_CTX = 16,
   parameter int CTX_W   = 4,
   parameter int ROW_W   = 3,
   parameter int ROW_ID  = 0,
   parameter int CTRL_W  = 13,
   parameter bit NORM_EN = 1'b1
) (
   input  logic              wr,
   input  logic [ROW_W-1:0]  row,
   input  logic [CTX_W-1:0]  ctx,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic [NUM_CTX-1:0] we_hot,
   output logic [CTRL_W-1:0] ctrl_out
);
   localparam int NPOS = lctx_pkg::norm_pos(CTRL_W);

   logic row_hit;
   assign row_hit = wr && (row == ROW_W'(ROW_ID));

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_dec
      assign we_hot[i] = row_hit && (ctx == CTX_W'(i));
   end

   if (NORM_EN) begin : g_norm_keep
      assign ctrl_out = ctrl_in;
   end else begin : g_norm_drop
      always_comb begin
         ctrl_out       = ctrl_in;
         ctrl_out[NPOS] = 1'b0;
      end
   end
endmodule

// File: rtl/lctx_bank.sv
module lctx_bank #(
   parameter int NUM_CTX = 16,
   parameter int CTX_W   = 4,
   parameter int ENT_W   = 45,
   parameter logic [ENT_W-1:0] RST0 = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] we_hot,
   input  logic [ENT_W-1:0]   wdata,
   input  logic [CTX_W-1:0]   rd_idx,
   output logic [ENT_W-1:0]   rd_data
);
   logic [ENT_W-1:0] mem [NUM_CTX];

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ent
      localparam logic [ENT_W-1:0] RV = (i == 0) ? RST0 : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         mem[i] <= RV;
         else if (we_hot[i]) mem[i] <= wdata;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/lctx_hold.sv
module lctx_hold #(
   parameter int ENT_W = 45,
   parameter logic [ENT_W-1:0] RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ENT_W-1:0] d,
   output logic [ENT_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST;
      else if (load) q <= d;
   end
endmodule

// File: rtl/lctx_store.sv
module lctx_store #(
   parameter int COEF_W    = 16,
   parameter int NUM_CTX   = 16,
   parameter int TAP_DEPTH = 8,
   parameter int SHIFT_W   = 4,
   parameter int ROW_W     = 3,
   parameter int ROW_ID    = 0,
   parameter bit NORM_EN   = 1'b1,
   localparam int CTX_W    = $clog2(NUM_CTX),
   localparam int TAP_W    = $clog2(TAP_DEPTH),
   localparam int CTRL_W   = lctx_pkg::ctrl_width(TAP_W, SHIFT_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [ROW_W-1:0]   cfg_row,
   input  logic [CTX_W-1:0]   cfg_ctx,
   input  logic [COEF_W-1:0]  cfg_coef_a,
   input  logic [COEF_W-1:0]  cfg_coef_b,
   input  logic [CTRL_W-1:0]  cfg_ctrl,
   input  logic               step_start,
   input  logic [CTX_W-1:0]   ctx_sel,
   output logic [COEF_W-1:0]  act_coef_a,
   output logic [COEF_W-1:0]  act_coef_b,
   output logic [TAP_W-1:0]   act_tap_p,
   output logic [TAP_W-1:0]   act_tap_q,
   output logic [SHIFT_W-1:0] act_shift,
   output logic               act_future,
   output logic               act_bypass,
   output logic               act_norm
);
   localparam int ENT_W = 2 * COEF_W + CTRL_W;
   localparam int BPOS  = lctx_pkg::bypass_pos(CTRL_W);
   localparam int NPOS  = lctx_pkg::norm_pos(CTRL_W);
   localparam int FPOS  = lctx_pkg::future_pos(CTRL_W);
   localparam logic [ENT_W-1:0] BYP_ENT = ENT_W'(1) << BPOS;

   if (NUM_CTX < 2 || (1 << CTX_W) != NUM_CTX) begin : g_bad_ctx
      $error("NUM_CTX must be a power of two of at least 2");
   end
   if (TAP_DEPTH < 2 || SHIFT_W < 1 || COEF_W < 2) begin : g_bad_w
      $error("TAP_DEPTH, SHIFT_W or COEF_W out of range");
   end
   if (ROW_ID < 0 || ROW_ID >= (1 << ROW_W)) begin : g_bad_row
      $error("ROW_ID does not fit in ROW_W bits");
   end

   logic [NUM_CTX-1:0] we_hot;
   logic [CTRL_W-1:0]  ctrl_w;
   logic [ENT_W-1:0]   rd_data;
   logic [ENT_W-1:0]   hold_q;

   lctx_wr_gate #(
      .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ROW_W(ROW_W), .ROW_ID(ROW_ID),
      .CTRL_W(CTRL_W), .NORM_EN(NORM_EN)
   ) u_gate (
      .wr(cfg_wr), .row(cfg_row), .ctx(cfg_ctx), .ctrl_in(cfg_ctrl),
      .we_hot(we_hot), .ctrl_out(ctrl_w)
   );

   lctx_bank #(
      .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ENT_W(ENT_W), .RST0(BYP_ENT)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .we_hot(we_hot),
      .wdata({cfg_coef_a, cfg_coef_b, ctrl_w}),
      .rd_idx(ctx_sel), .rd_data(rd_data)
   );

   lctx_hold #(.ENT_W(ENT_W), .RST(BYP_ENT)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(step_start), .d(rd_data), .q(hold_q)
   );

   assign act_coef_a = hold_q[ENT_W-1 -: COEF_W];
   assign act_coef_b = hold_q[CTRL_W +: COEF_W];
   assign act_tap_p  = hold_q[0 +: TAP_W];
   assign act_tap_q  = hold_q[TAP_W +: TAP_W];
   assign act_shift  = hold_q[2*TAP_W +: SHIFT_W];
   assign act_future = hold_q[FPOS];
   assign act_bypass = hold_q[BPOS];
   assign act_norm   = hold_q[NPOS];

   // R2
   row_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_row != ROW_W'(ROW_ID)) |-> (we_hot == '0));

   // R2
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_hot));

   // R4
   step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_start |=> (hold_q == $past(rd_data)));

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_start |=> $stable({act_coef_a, act_coef_b, act_tap_p, act_tap_q,
                               act_shift, act_future, act_bypass, act_norm}));

   if (!NORM_EN) begin : g_norm_chk
      // R7
      norm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !act_norm);
   end
endmodule

// File: tb/lctx_store_tb.sv
module lctx_store_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MY_ROW  = 5;
   localparam int MID_ROW = 2;
   localparam int ENT_W   = 45;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_row = '0;
   logic [3:0]  cfg_ctx = '0;
   logic [15:0] cfg_coef_a = '0;
   logic [15:0] cfg_coef_b = '0;
   logic [12:0] cfg_ctrl = '0;
   logic        step_start = 1'b0;
   logic [3:0]  ctx_sel = '0;

   logic [15:0] a_o, b_o, ma_o, mb_o;
   logic [2:0]  tp_o, tq_o, mtp_o, mtq_o;
   logic [3:0]  sh_o, msh_o;
   logic        fu_o, by_o, no_o, mfu_o, mby_o, mno_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [ENT_W-1:0] model [16];
   logic [ENT_W-1:0] q_exp [$];
   string            q_tag [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lctx_store #(.ROW_ID(MY_ROW), .NORM_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_row(cfg_row),
      .cfg_ctx(cfg_ctx), .cfg_coef_a(cfg_coef_a), .cfg_coef_b(cfg_coef_b),
      .cfg_ctrl(cfg_ctrl), .step_start(step_start), .ctx_sel(ctx_sel),
      .act_coef_a(a_o), .act_coef_b(b_o), .act_tap_p(tp_o), .act_tap_q(tq_o),
      .act_shift(sh_o), .act_future(fu_o), .act_bypass(by_o), .act_norm(no_o)
   );

   lctx_store #(.ROW_ID(MID_ROW), .NORM_EN(1'b0)) u_mid (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_row(cfg_row),
      .cfg_ctx(cfg_ctx), .cfg_coef_a(cfg_coef_a), .cfg_coef_b(cfg_coef_b),
      .cfg_ctrl(cfg_ctrl), .step_start(step_start), .ctx_sel(ctx_sel),
      .act_coef_a(ma_o), .act_coef_b(mb_o), .act_tap_p(mtp_o), .act_tap_q(mtq_o),
      .act_shift(msh_o), .act_future(mfu_o), .act_bypass(mby_o), .act_norm(mno_o)
   );

   function automatic logic [ENT_W-1:0] dut_out();
      return {a_o, b_o, no_o, by_o, fu_o, sh_o, tq_o, tp_o};
   endfunction

   task automatic check(input string tag, input logic [ENT_W-1:0] act,
                        input logic [ENT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic load(input int row, input int ctx, input logic [15:0] a,
                       input logic [15:0] b, input logic [12:0] c);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_row = 3'(row); cfg_ctx = 4'(ctx);
      cfg_coef_a = a; cfg_coef_b = b; cfg_ctrl = c;
      if (row == MY_ROW) model[ctx] = {a, b, c};
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic step(input int ctx, input string tag);
      @(negedge clk);
      ctx_sel = 4'(ctx); step_start = 1'b1;
      q_exp.push_back(model[ctx]); q_tag.push_back(tag);
      @(negedge clk);
      step_start = 1'b0;
   endtask

   // monitor: compare one cycle after each step strobe
   initial begin
      forever begin
         @(posedge clk);
         if (step_start && rst_n) begin
            @(negedge clk);
            if (q_exp.size() > 0)
               check(q_tag.pop_front(), dut_out(), q_exp.pop_front());
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [ENT_W-1:0] byp;
      logic [ENT_W-1:0] held;
      byp = ENT_W'(1) << 11;
      for (int i = 0; i < 16; i++) model[i] = '0;
      model[0] = byp;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset outputs
      check("R1 reset outputs", dut_out(), byp);
      step(0, "R1 ctx0 bypass");
      step(5, "R1 other ctx zero");

      // R3 field round trip, several patterns
      load(MY_ROW, 1, 16'h1234, 16'hFEDC, 13'b0_0_1_1010_011_101);
      step(1, "R3 pattern one");
      load(MY_ROW, 2, 16'h8000, 16'h7FFF, 13'b1_1_0_0101_110_010);
      step(2, "R3 pattern two");
      load(MY_ROW, 7, 16'h00FF, 16'hAA55, 13'h1FFF);
      step(7, "R4 select ctx7");
      step(1, "R4 back to ctx1");

      // R2 other rows do not write
      load(3, 1, 16'hDEAD, 16'hBEEF, 13'h0F0F);
      load(MID_ROW, 4, 16'h0101, 16'h0202, 13'h1ABC);
      step(1, "R2 foreign row ctx1");
      step(4, "R2 foreign row ctx4");

      // R8 last context
      load(MY_ROW, 15, 16'h5A5A, 16'hA5A5, 13'h0C33);
      step(15, "R8 last ctx");

      // R5 select move and rewrite of active entry with no strobe
      held = model[15];
      @(negedge clk);
      ctx_sel = 4'd2;
      load(MY_ROW, 15, 16'h1111, 16'h2222, 13'h0111);
      repeat (3) @(negedge clk);
      check("R5 hold while running", dut_out(), held);
      step(15, "R5 rewrite seen next step");

      // R6 load and step together on same ctx
      @(negedge clk);
      ctx_sel = 4'd6; step_start = 1'b1;
      cfg_wr = 1'b1; cfg_row = 3'(MY_ROW); cfg_ctx = 4'd6;
      cfg_coef_a = 16'h0666; cfg_coef_b = 16'h0999; cfg_ctrl = 13'h1555;
      q_exp.push_back(model[6]); q_tag.push_back("R6 same edge old value");
      model[6] = {16'h0666, 16'h0999, 13'h1555};
      @(negedge clk);
      step_start = 1'b0; cfg_wr = 1'b0;
      step(6, "R6 new value next step");

      // R7 middle element drops normalize
      step(4, "R2 dut ctx4 still zero");
      @(negedge clk);
      check("R7 mid norm zero", {47'(0), mno_o}, '0);
      check("R7 mid other fields", {ma_o, mb_o, mby_o, mfu_o, msh_o, mtq_o, mtp_o},
            {16'h0101, 16'h0202, 1'b1, 1'b0, 4'hA, 3'b111, 3'b100});

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule